// File: doc/BRIEF.md
# Byte-Code Operand Fetch and Dispatch Helper

This unit sits beside the decoder of a small 8-bit processor core and carries out the three operations that make a byte-code interpreter loop cheap. It owns a 16-bit instruction pointer that is kept apart from the program counter. The decoder raises one of three command strobes. The first reads the next operand byte from the alternate memory bank into the accumulator and then advances the pointer. The second trades the pointer for the Y:A register pair. The third makes an indirect jump through a two-byte entry in a dispatch table. The table entry is selected by a page operand and the current accumulator value.

The unit drives a simple read port. A read request, its address and a bank flag go out in one cycle, and the addressed byte comes back on the read-data input during the following cycle. Results return to the core through write strobes for A, Y and the program counter. A busy output stays high while a multi-cycle operation is still running, and the core holds its next command until busy drops. The exchange finishes in the same cycle it is issued and never raises busy.

Top module: `bcvm_fetch_dispatch`

## Requirements
- R1: While reset is low and in the first cycle after it, busy, mem_req and all write strobes are low, and ip_value equals the IP_RESET parameter.
- R2: A fetch command accepted while idle drives mem_req high, mem_alt_bank high (1 = alternate bank) and mem_addr equal to the current ip_value, all in the cycle the command is seen.
- R3: In the cycle after a fetch is accepted, busy is high, a_we is high and a_wdata equals the byte on mem_rdata in that cycle.
- R4: Each accepted fetch raises ip_value by exactly one, modulo 65536, so 0xFFFF wraps to 0x0000. No other output changes because of the wrap.
- R5: An exchange command completes in its own cycle with busy low. a_we carries the old IP low byte, y_we carries the old IP high byte, and from the next cycle ip_value equals {reg_y, reg_a} as sampled with the command.
- R6: An accepted jump reads the main bank (mem_alt_bank = 0) first at {jump_page, reg_a}. In the next cycle it reads that address plus one as a full 16-bit sum, so reg_a = 0xFF carries into the following page.
- R7: In the third cycle of a jump, pc_we is high and pc_wdata holds the byte from the second read in bits 15:8 and the byte from the first read in bits 7:0.
- R8: busy is high in every follow-on cycle of a fetch or jump. Any command presented in those cycles is ignored: it causes no extra request, no write strobe and no change to ip_value.
- R9: If several commands arrive together while idle, fetch is taken over jump and jump over exchange. The losing commands have no effect.
- R10: While idle with no command, mem_req and all write strobes stay low and ip_value holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_fetch | input | 1 | Fetch operand byte and advance the pointer |
| cmd_swap | input | 1 | Exchange the pointer with Y:A |
| cmd_jump | input | 1 | Indirect jump through the dispatch table |
| jump_page | input | DW | Page operand of the jump |
| reg_a | input | DW | Current accumulator value |
| reg_y | input | DW | Current Y register value |
| mem_rdata | input | DW | Read data, valid the cycle after a request |
| busy | output | 1 | Multi-cycle operation in progress |
| mem_req | output | 1 | Read request |
| mem_alt_bank | output | 1 | 1 selects the alternate bank |
| mem_addr | output | 2*DW | Read address |
| a_we | output | 1 | Write strobe for A |
| a_wdata | output | DW | Data for A |
| y_we | output | 1 | Write strobe for Y |
| y_wdata | output | DW | Data for Y |
| pc_we | output | 1 | Program counter load strobe |
| pc_wdata | output | 2*DW | Program counter load value |
| ip_value | output | 2*DW | Current instruction pointer |

## Verification
The bench builds the unit with DW = 8 and IP_RESET = 0xFFFE. The second fetch after reset therefore crosses the 0xFFFF to 0x0000 wrap without a long run. Its memory model returns an address-derived byte that differs between the two banks. A read from the wrong bank, or a pointer with its bytes in the wrong order, shows up in the written values. The stimulus places commands in the busy cycles, sets reg_a to 0xFF to force the page carry, and raises all three strobes together to test priority.

// File: rtl/bcvm_pkg.sv
package bcvm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_FETCH_WB = 2'd1,
        ST_PTR_LO   = 2'd2,
        ST_PTR_HI   = 2'd3
    } bcvm_state_e;

endpackage

// File: rtl/bcvm_ip_reg.sv
module bcvm_ip_reg #(
    parameter int DW = 8,
    parameter logic [2*DW-1:0] IP_RESET = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ip_inc,
    input  logic            ip_load,
    input  logic [2*DW-1:0] ip_load_val,
    output logic [2*DW-1:0] ip
);
    localparam int AW = 2 * DW;

    logic [AW-1:0] ip_d, ip_q;

    always_comb begin
        ip_d = ip_q;
        if (ip_load) begin
            ip_d = ip_load_val;
        end else if (ip_inc) begin
            ip_d = ip_q + AW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ip_q <= IP_RESET;
        end else begin
            ip_q <= ip_d;
        end
    end

    assign ip = ip_q;

    // R4: one step forward per accepted fetch, wrapping at the top
    p_ip_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ip_inc && !ip_load) |=> ip_q == $past(ip_q) + AW'(1));

    // R10: the pointer holds when neither control is raised
    p_ip_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ip_inc && !ip_load) |=> $stable(ip_q));

    p_ip_ctrl_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(ip_inc && ip_load));

endmodule

// File: rtl/bcvm_ctrl.sv
module bcvm_ctrl
    import bcvm_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_fetch,
    input  logic            cmd_swap,
    input  logic            cmd_jump,
    input  logic [DW-1:0]   jump_page,
    input  logic [DW-1:0]   reg_a,
    input  logic [DW-1:0]   reg_y,
    input  logic [2*DW-1:0] ip,
    input  logic [DW-1:0]   mem_rdata,
    output logic            busy,
    output logic            mem_req,
    output logic            mem_alt_bank,
    output logic [2*DW-1:0] mem_addr,
    output logic            a_we,
    output logic [DW-1:0]   a_wdata,
    output logic            y_we,
    output logic [DW-1:0]   y_wdata,
    output logic            pc_we,
    output logic [2*DW-1:0] pc_wdata,
    output logic            ip_inc,
    output logic            ip_load,
    output logic [2*DW-1:0] ip_load_val
);
    localparam int AW = 2 * DW;

    typedef struct packed {
        bcvm_state_e   st;
        logic [AW-1:0] ptr;
        logic [DW-1:0] lo;
    } ctrl_regs_t;

    ctrl_regs_t r_d, r_q;

    always_comb begin
        r_d          = r_q;
        busy         = 1'b0;
        mem_req      = 1'b0;
        mem_alt_bank = 1'b0;
        mem_addr     = '0;
        a_we         = 1'b0;
        a_wdata      = '0;
        y_we         = 1'b0;
        y_wdata      = '0;
        pc_we        = 1'b0;
        pc_wdata     = '0;
        ip_inc       = 1'b0;
        ip_load      = 1'b0;
        ip_load_val  = '0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (cmd_fetch) begin
                    mem_req      = 1'b1;
                    mem_alt_bank = 1'b1;
                    mem_addr     = ip;
                    ip_inc       = 1'b1;
                    r_d.st       = ST_FETCH_WB;
                end else if (cmd_jump) begin
                    mem_req  = 1'b1;
                    mem_addr = {jump_page, reg_a};
                    r_d.ptr  = {jump_page, reg_a};
                    r_d.st   = ST_PTR_LO;
                end else if (cmd_swap) begin
                    a_we        = 1'b1;
                    a_wdata     = ip[DW-1:0];
                    y_we        = 1'b1;
                    y_wdata     = ip[AW-1:DW];
                    ip_load     = 1'b1;
                    ip_load_val = {reg_y, reg_a};
                end
            end
            ST_FETCH_WB: begin
                busy    = 1'b1;
                a_we    = 1'b1;
                a_wdata = mem_rdata;
                r_d.st  = ST_IDLE;
            end
            ST_PTR_LO: begin
                busy     = 1'b1;
                mem_req  = 1'b1;
                mem_addr = r_q.ptr + AW'(1);
                r_d.lo   = mem_rdata;
                r_d.st   = ST_PTR_HI;
            end
            ST_PTR_HI: begin
                busy     = 1'b1;
                pc_we    = 1'b1;
                pc_wdata = {mem_rdata, r_q.lo};
                r_d.st   = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, ptr: '0, lo: '0};
        end else begin
            r_q <= r_d;
        end
    end

    // R3: an accepted fetch writes A in the very next cycle, under busy
    p_fetch_wb_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && cmd_fetch) |=> (busy && a_we && !pc_we));

    // R6: the second table read follows the first by one address
    p_ptr_second_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && !cmd_fetch && cmd_jump) |=>
        (mem_req && !mem_alt_bank && mem_addr == $past({jump_page, reg_a}) + AW'(1)));

    // R7: the program counter load comes straight after the second read
    p_pc_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mem_req) |=> (pc_we && busy));

    // R8: no exchange or alternate-bank read can start under busy
    p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(y_we || ip_inc || ip_load || mem_alt_bank));

endmodule

// File: rtl/bcvm_fetch_dispatch.sv
module bcvm_fetch_dispatch #(
    parameter int DW = 8,
    parameter logic [2*DW-1:0] IP_RESET = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_fetch,
    input  logic            cmd_swap,
    input  logic            cmd_jump,
    input  logic [DW-1:0]   jump_page,
    input  logic [DW-1:0]   reg_a,
    input  logic [DW-1:0]   reg_y,
    input  logic [DW-1:0]   mem_rdata,
    output logic            busy,
    output logic            mem_req,
    output logic            mem_alt_bank,
    output logic [2*DW-1:0] mem_addr,
    output logic            a_we,
    output logic [DW-1:0]   a_wdata,
    output logic            y_we,
    output logic [DW-1:0]   y_wdata,
    output logic            pc_we,
    output logic [2*DW-1:0] pc_wdata,
    output logic [2*DW-1:0] ip_value
);
    localparam int AW = 2 * DW;

    logic          ip_inc;
    logic          ip_load;
    logic [AW-1:0] ip_load_val;

    bcvm_ctrl #(.DW(DW)) ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_fetch    (cmd_fetch),
        .cmd_swap     (cmd_swap),
        .cmd_jump     (cmd_jump),
        .jump_page    (jump_page),
        .reg_a        (reg_a),
        .reg_y        (reg_y),
        .ip           (ip_value),
        .mem_rdata    (mem_rdata),
        .busy         (busy),
        .mem_req      (mem_req),
        .mem_alt_bank (mem_alt_bank),
        .mem_addr     (mem_addr),
        .a_we         (a_we),
        .a_wdata      (a_wdata),
        .y_we         (y_we),
        .y_wdata      (y_wdata),
        .pc_we        (pc_we),
        .pc_wdata     (pc_wdata),
        .ip_inc       (ip_inc),
        .ip_load      (ip_load),
        .ip_load_val  (ip_load_val)
    );

    bcvm_ip_reg #(.DW(DW), .IP_RESET(IP_RESET)) ip_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ip_inc      (ip_inc),
        .ip_load     (ip_load),
        .ip_load_val (ip_load_val),
        .ip          (ip_value)
    );

    // R5: after an exchange the pointer holds the former Y:A pair
    p_swap_ip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        y_we |=> ip_value == {$past(reg_y), $past(reg_a)});

    // R2: a fetch from idle addresses the alternate bank at the pointer
    p_fetch_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_fetch) |-> (mem_req && mem_alt_bank && mem_addr == ip_value));

    // R10: nothing leaves the unit when idle and unasked
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cmd_fetch && !cmd_swap && !cmd_jump) |-> !(mem_req || a_we || y_we || pc_we));

endmodule

// File: tb/bcvm_fetch_dispatch_tb_top.sv
module bcvm_fetch_dispatch_tb_top;
    localparam int DW = 8;
    localparam int AW = 16;
    localparam logic [15:0] IP_RST = 16'hFFFE;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic cmd_fetch = 0, cmd_swap = 0, cmd_jump = 0;
    logic [7:0] jump_page = '0, reg_a = '0, reg_y = '0;
    logic [7:0] mem_rdata = '0;
    logic busy, mem_req, mem_alt_bank, a_we, y_we, pc_we;
    logic [15:0] mem_addr, pc_wdata, ip_value;
    logic [7:0] a_wdata, y_wdata;

    bcvm_fetch_dispatch #(.DW(DW), .IP_RESET(IP_RST)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_fetch(cmd_fetch), .cmd_swap(cmd_swap),
        .cmd_jump(cmd_jump), .jump_page(jump_page), .reg_a(reg_a), .reg_y(reg_y),
        .mem_rdata(mem_rdata), .busy(busy), .mem_req(mem_req),
        .mem_alt_bank(mem_alt_bank), .mem_addr(mem_addr), .a_we(a_we),
        .a_wdata(a_wdata), .y_we(y_we), .y_wdata(y_wdata), .pc_we(pc_we),
        .pc_wdata(pc_wdata), .ip_value(ip_value)
    );

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    function automatic logic [7:0] mem_byte(input logic alt, input logic [15:0] ad);
        if (alt) return ad[7:0] * 8'd7 + ad[15:8] + 8'd3;
        return ad[7:0] ^ ad[15:8] ^ 8'h5A;
    endfunction

    // memory: answers in the cycle after the request
    always @(posedge clk) if (mem_req) mem_rdata <= mem_byte(mem_alt_bank, mem_addr);

    // behavioural reference: phase 0 idle, 1 fetch writeback, 2/3 table reads
    int ph = 0;
    logic [15:0] m_ip = IP_RST;
    logic [15:0] m_fa = '0;
    logic [15:0] m_ptr = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0;
            m_ip = IP_RST;
        end else begin
            case (ph)
                0: begin
                    if (cmd_fetch) begin
                        m_fa = m_ip; m_ip = m_ip + 16'd1; ph = 1;
                    end else if (cmd_jump) begin
                        m_ptr = {jump_page, reg_a}; ph = 2;
                    end else if (cmd_swap) begin
                        m_ip = {reg_y, reg_a};
                    end
                end
                1: ph = 0;
                2: ph = 3;
                default: ph = 0;
            endcase
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        #1;
        if (!done) begin
            string tag;
            logic e_busy, e_req, e_alt, e_awe, e_ywe, e_pcwe;
            logic [15:0] e_addr, e_pcwd;
            logic [7:0] e_awd, e_ywd;
            int ncmd;
            ncmd = int'(cmd_fetch) + int'(cmd_swap) + int'(cmd_jump);
            e_busy = 0; e_req = 0; e_alt = 0; e_addr = '0; e_awe = 0; e_awd = '0;
            e_ywe = 0; e_ywd = '0; e_pcwe = 0; e_pcwd = '0;
            tag = "R10";
            if (!rst_n) begin
                tag = "R1";
            end else if (ph == 1) begin
                tag = "R3"; e_busy = 1; e_awe = 1; e_awd = mem_byte(1'b1, m_fa);
            end else if (ph == 2) begin
                tag = "R6"; e_busy = 1; e_req = 1; e_addr = m_ptr + 16'd1;
            end else if (ph == 3) begin
                tag = "R7"; e_busy = 1; e_pcwe = 1;
                e_pcwd = {mem_byte(1'b0, m_ptr + 16'd1), mem_byte(1'b0, m_ptr)};
            end else if (cmd_fetch) begin
                tag = (ncmd > 1) ? "R9" : "R2";
                e_req = 1; e_alt = 1; e_addr = m_ip;
            end else if (cmd_jump) begin
                tag = (ncmd > 1) ? "R9" : "R6";
                e_req = 1; e_addr = {jump_page, reg_a};
            end else if (cmd_swap) begin
                tag = "R5"; e_awe = 1; e_awd = m_ip[7:0]; e_ywe = 1; e_ywd = m_ip[15:8];
            end
            if (rst_n && ph != 0 && ncmd > 0) tag = "R8";
            chk(tag, "busy", 16'(busy), 16'(e_busy));
            chk(tag, "mem_req", 16'(mem_req), 16'(e_req));
            if (e_req) begin
                chk(tag, "mem_alt_bank", 16'(mem_alt_bank), 16'(e_alt));
                chk(tag, "mem_addr", mem_addr, e_addr);
            end
            chk(tag, "a_we", 16'(a_we), 16'(e_awe));
            if (e_awe) chk(tag, "a_wdata", 16'(a_wdata), 16'(e_awd));
            chk(tag, "y_we", 16'(y_we), 16'(e_ywe));
            if (e_ywe) chk(tag, "y_wdata", 16'(y_wdata), 16'(e_ywd));
            chk(tag, "pc_we", 16'(pc_we), 16'(e_pcwe));
            if (e_pcwe) chk(tag, "pc_wdata", pc_wdata, e_pcwd);
            chk((tag == "R1" || tag == "R5" || tag == "R8") ? tag : "R4", "ip_value", ip_value, m_ip);
        end
    end

    task automatic drv(input logic f, input logic s, input logic j,
                       input logic [7:0] pg, input logic [7:0] a, input logic [7:0] y);
        @(negedge clk);
        cmd_fetch = f; cmd_swap = s; cmd_jump = j;
        jump_page = pg; reg_a = a; reg_y = y;
    endtask

    task automatic quiet(input int n);
        for (int k = 0; k < n; k++) drv(0, 0, 0, 8'h00, 8'h00, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        quiet(1);                              // R1 first cycle after reset, R10
        drv(1, 0, 0, 8'h00, 8'h00, 8'h00);     // R2 fetch at 0xFFFE
        quiet(1);                              // R3 writeback
        drv(1, 0, 0, 8'h00, 8'h00, 8'h00);     // R4 fetch at 0xFFFF, wraps
        drv(0, 1, 0, 8'h00, 8'h77, 8'h66);     // R8 exchange under busy ignored
        drv(1, 0, 0, 8'h00, 8'h00, 8'h00);     // fetch at 0x0000
        drv(1, 1, 1, 8'h20, 8'h30, 8'h40);     // R8 all strobes under busy
        drv(0, 1, 0, 8'h00, 8'h34, 8'h12);     // R5 exchange
        quiet(1);
        drv(0, 0, 1, 8'h80, 8'h10, 8'h00);     // R6 R7 jump
        drv(1, 0, 1, 8'h11, 8'h22, 8'h00);     // R8 under busy
        drv(0, 1, 0, 8'h00, 8'h01, 8'h02);     // R8 under busy
        quiet(1);
        drv(0, 0, 1, 8'h3C, 8'hFF, 8'h00);     // R6 page carry
        quiet(3);
        drv(1, 1, 1, 8'h55, 8'h66, 8'h77);     // R9 fetch wins
        quiet(2);
        drv(0, 1, 1, 8'h9A, 8'hBC, 8'hDE);     // R9 jump wins over exchange
        quiet(3);
        for (int i = 0; i < 80; i++) begin
            int k;
            k = i % 5;
            drv(k == 0 || k == 4, k == 1, k == 2, 8'(i * 3), (i % 7 == 0) ? 8'hFF : 8'(i * 11), 8'(i * 5));
            drv(k == 2, k == 0, k == 1, 8'(i), 8'(i + 1), 8'(i + 2));
            quiet(i % 3);
        end
        quiet(4);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        done = 1;
        n_fail++;
        $display("FAIL R8 watchdog actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule